// File: doc/BRIEF.md
# Stack and Memory Word Access Unit

This unit moves 32-bit words between a register-side request interface and a byte-wide memory with a 24-bit address space. It handles six operations: pushing a word onto the stack, popping a word off it, loading through an address register, storing through an address register, setting the stack pointer from an immediate, and fetching an instruction word. The unit owns the 24-bit stack pointer. It splits every word transfer into four single-byte memory cycles, issued one per clock at ascending addresses.

Data words move least significant byte first. Instruction fetch is the exception: it assembles the word most significant byte first. Address checks look only at the upper byte of a 32-bit address operand, and an operation that fails the check ends with an error. A store to the top word of memory also presents the stored word on a terminal output strobe, so a character device can take it without any decoding of its own.

The requester raises `req_i` with an operation code while `busy_o` is low. It then waits for the one-cycle `done_o` pulse. Load, pop and fetch results are valid on `rdata_o` from that pulse onwards.

Top module: `stack_mem_unit`

## Requirements
- R1: After reset the stack pointer is 0, `busy_o`, `done_o`, `err_o` and `term_valid_o` are low, and no memory read or write is issued.
- R2: Push (op 0) writes the data word to bytes SP, SP+1, SP+2 and SP+3. The byte at SP is bits 7:0, and each following byte is the next 8 bits. SP then becomes SP+4.
- R3: Pop (op 1) first lowers SP by 4. It then reads bytes SP..SP+3 and assembles them with the byte at SP as bits 7:0. The result appears on `rdata_o`.
- R4: Load (op 2) reads four bytes starting at `addr_i[23:0]`, least significant byte first. If `addr_i[31:24]` is non-zero, the load ends with `err_o` set. It issues no memory access, and `rdata_o` keeps its previous value.
- R5: Store (op 3) writes the data word least significant byte first, starting at `addr_i[23:0]`. Bits 31:24 of the address are ignored.
- R6: A store whose 24-bit address is 0xFFFFFC pulses `term_valid_o` together with `done_o`, with the stored word on `term_data_o`. No other operation or address pulses it.
- R7: Set-SP (op 4) loads SP from `data_i[23:0]`. If `data_i[31:24]` is non-zero, it ends with `err_o` set and SP is unchanged.
- R8: Fetch (op 5) reads four bytes starting at `addr_i[23:0]`. The first byte becomes bits 31:24 of `rdata_o`, and the last byte becomes bits 7:0.
- R9: A word transfer holds `busy_o` high for exactly four cycles. Each of those cycles carries one byte access, at base+0 through base+3. `done_o` pulses in the cycle after the last byte. Set-SP and rejected operations pulse `done_o` in the cycle after the request, with no busy cycle.
- R10: A request raised while `busy_o` is high is ignored.
- R11: SP and byte addresses wrap modulo 2^24. A push at SP=0xFFFFFC leaves SP at 0, and a pop at SP=0 leaves SP at 0xFFFFFC.
- R12: Op codes 6 and 7 end with `err_o` set. They access no memory and leave SP unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request, taken while not busy |
| op_i | input | 3 | Operation code |
| data_i | input | 32 | Word to push or store, or immediate for set-SP |
| addr_i | input | 32 | Address register value for load, store and fetch |
| busy_o | output | 1 | Word transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operation rejected, valid with done |
| rdata_o | output | 32 | Result of the last load, pop or fetch |
| sp_o | output | 24 | Stack pointer |
| mem_addr_o | output | 24 | Byte address |
| mem_we_o | output | 1 | Byte write enable |
| mem_re_o | output | 1 | Byte read enable |
| mem_wdata_o | output | 8 | Byte write data |
| mem_rdata_i | input | 8 | Byte read data, same cycle as the address |
| term_valid_o | output | 1 | Terminal output strobe |
| term_data_o | output | 32 | Word written to the terminal address |

## Verification
The hardest case to reach from the ports is a new request that arrives while a transfer is in flight, because a correct design leaves no trace of it. The bench keeps `req_i` high with a conflicting set-SP request through three of the four busy cycles of a push. It then checks that SP ends at the pushed value plus 4 and not at the immediate. The stack pointer is also driven to the very top of the address space, so the push wraps SP to zero and the following pop wraps it back. The bytes written by that push land at 0xFFFFFC..0xFFFFFF, and the bench confirms that this push raises no terminal strobe even though it covers the terminal word.

// File: rtl/smu_pkg.sv
package smu_pkg;
  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_SETSP = 3'd4,
    OP_FETCH = 3'd5
  } smu_op_e;
endpackage

// File: rtl/smu_sp_reg.sv
module smu_sp_reg #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  output logic [ADDR_W-1:0] sp_o
);
  localparam logic [ADDR_W-1:0] Step = ADDR_W'(STEP);

  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= load_val_i;
    else if (inc_i)  sp_q <= sp_q + Step;
    else if (dec_i)  sp_q <= sp_q - Step;
  end

  assign sp_o = sp_q;

  // R10
  sp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i || dec_i || load_i) |=> $stable(sp_o));
endmodule

// File: rtl/smu_byte_seq.sv
module smu_byte_seq #(
  parameter int unsigned NB = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  output logic                  active_o,
  output logic [$clog2(NB)-1:0] idx_o,
  output logic                  last_o
);
  localparam int unsigned IW = $clog2(NB);
  localparam logic [IW-1:0] LastIdx = IW'(NB - 1);

  logic          active_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == LastIdx) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign last_o   = active_q && (idx_q == LastIdx);

  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> !start_i);

  // R9
  idx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> idx_o == '0);
endmodule

// File: rtl/smu_lane_buf.sv
module smu_lane_buf #(
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NB*BW-1:0]      load_word_i,
  input  logic                  wr_i,
  input  logic [$clog2(NB)-1:0] lane_i,
  input  logic [BW-1:0]         wr_byte_i,
  output logic [BW-1:0]         rd_byte_o,
  output logic [NB*BW-1:0]      word_o,
  output logic [NB*BW-1:0]      word_nxt_o
);
  localparam int unsigned WW = NB * BW;

  logic [WW-1:0] word_q;
  logic [WW-1:0] word_d;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign word_d[g*BW +: BW] =
      load_i                              ? load_word_i[g*BW +: BW] :
      (wr_i && lane_i == $clog2(NB)'(g))  ? wr_byte_i               :
                                            word_q[g*BW +: BW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign rd_byte_o  = word_q[lane_i*BW +: BW];
  assign word_o     = word_q;
  assign word_nxt_o = word_d;
endmodule

// File: rtl/stack_mem_unit.sv
module stack_mem_unit
  import smu_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 32,
  parameter int unsigned       BYTE_W    = 8,
  parameter logic [ADDR_W-1:0] TERM_ADDR = ADDR_W'('hFFFFFC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              term_valid_o,
  output logic [DATA_W-1:0] term_data_o
);
  localparam int unsigned NB = DATA_W / BYTE_W;
  localparam int unsigned LW = $clog2(NB);
  localparam logic [ADDR_W-1:0] WordBytes = ADDR_W'(NB);

  smu_op_e op;
  logic    accept, addr_hi_bad, data_hi_bad;
  logic    go_xfer, go_wr, go_big, go_push, go_term, go_err;
  logic    sp_dec, sp_load, sp_inc;
  logic [ADDR_W-1:0] go_base, sp;

  logic              active, last;
  logic [LW-1:0]     idx, lane;
  logic [ADDR_W-1:0] base_q;
  logic              wr_q, big_q, push_q, term_q;
  logic              done_q, err_q, term_v_q;
  logic [DATA_W-1:0] rdata_q, buf_word, buf_nxt;
  logic [BYTE_W-1:0] buf_byte;

  assign op          = smu_op_e'(op_i);
  assign accept      = req_i && !active;
  assign addr_hi_bad = |addr_i[DATA_W-1:ADDR_W];
  assign data_hi_bad = |data_i[DATA_W-1:ADDR_W];

  always_comb begin
    go_xfer = 1'b0;
    go_wr   = 1'b0;
    go_big  = 1'b0;
    go_push = 1'b0;
    go_term = 1'b0;
    go_err  = 1'b0;
    sp_dec  = 1'b0;
    sp_load = 1'b0;
    go_base = addr_i[ADDR_W-1:0];
    if (accept) begin
      case (op)
        OP_PUSH: begin
          go_xfer = 1'b1;
          go_wr   = 1'b1;
          go_push = 1'b1;
          go_base = sp;
        end
        OP_POP: begin
          go_xfer = 1'b1;
          sp_dec  = 1'b1;
          go_base = sp - WordBytes;
        end
        OP_LOAD: begin
          if (addr_hi_bad) go_err  = 1'b1;
          else             go_xfer = 1'b1;
        end
        OP_STORE: begin
          go_xfer = 1'b1;
          go_wr   = 1'b1;
          go_term = (addr_i[ADDR_W-1:0] == TERM_ADDR);
        end
        OP_SETSP: begin
          if (data_hi_bad) go_err  = 1'b1;
          else             sp_load = 1'b1;
        end
        OP_FETCH: begin
          go_xfer = 1'b1;
          go_big  = 1'b1;
        end
        default: go_err = 1'b1;
      endcase
    end
  end

  smu_byte_seq #(.NB(NB)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go_xfer),
    .active_o (active),
    .idx_o    (idx),
    .last_o   (last)
  );

  assign sp_inc = last && push_q;

  smu_sp_reg #(.ADDR_W(ADDR_W), .STEP(NB)) i_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (sp_inc),
    .dec_i      (sp_dec),
    .load_i     (sp_load),
    .load_val_i (data_i[ADDR_W-1:0]),
    .sp_o       (sp)
  );

  // big-endian fetch walks lanes from the top
  assign lane = big_q ? (LW'(NB - 1) - idx) : idx;

  smu_lane_buf #(.NB(NB), .BW(BYTE_W)) i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (go_xfer && go_wr),
    .load_word_i (data_i),
    .wr_i        (active && !wr_q),
    .lane_i      (lane),
    .wr_byte_i   (mem_rdata_i),
    .rd_byte_o   (buf_byte),
    .word_o      (buf_word),
    .word_nxt_o  (buf_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      wr_q     <= 1'b0;
      big_q    <= 1'b0;
      push_q   <= 1'b0;
      term_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      term_v_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (go_xfer) begin
        base_q <= go_base;
        wr_q   <= go_wr;
        big_q  <= go_big;
        push_q <= go_push;
        term_q <= go_term;
      end
      done_q   <= (accept && !go_xfer) || last;
      err_q    <= go_err;
      term_v_q <= last && term_q;
      if (last && !wr_q) rdata_q <= buf_nxt;
    end
  end

  assign busy_o       = active;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign rdata_o      = rdata_q;
  assign sp_o         = sp;
  assign mem_addr_o   = base_q + ADDR_W'(idx);
  assign mem_we_o     = active && wr_q;
  assign mem_re_o     = active && !wr_q;
  assign mem_wdata_o  = buf_byte;
  assign term_valid_o = term_v_q;
  assign term_data_o  = buf_word;

  // R9
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R6
  term_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_valid_o |-> done_o && !err_o);

  // R4
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R4
  err_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(rdata_o));
endmodule

// File: tb/test_stack_mem_unit.sv
module test_stack_mem_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] data = '0;
  logic [31:0] addr = '0;
  logic        busy, done, err, mem_we, mem_re, term_valid;
  logic [31:0] rdata, term_data;
  logic [23:0] sp, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] mem     [1024];
  logic [7:0] exp_mem [1024];

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] sp_m;
  logic        got_term;
  logic [31:0] got_term_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_mem_unit i_stack_mem_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .data_i(data), .addr_i(addr),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata), .sp_o(sp),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .term_valid_o(term_valid), .term_data_o(term_data)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  assign mem_rdata = mem[mem_addr[9:0]];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_le(input logic [23:0] b);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = exp_mem[10'(b + 24'(k))];
    return w;
  endfunction

  function automatic logic [31:0] rd_be(input logic [23:0] b);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*(3-k) +: 8] = exp_mem[10'(b + 24'(k))];
    return w;
  endfunction

  // R9: four busy cycles, one byte per cycle, done the cycle after
  task automatic xfer(input logic [2:0] o, input logic [31:0] d, input logic [31:0] a,
                      input logic [23:0] base, input bit wr, input bit big, input bit hold);
    @(negedge clk);
    req = 1'b1; op = o; data = d; addr = a;
    @(negedge clk);
    if (hold) begin op = 3'd4; data = 32'h0000_0123; end
    else req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [23:0] ea;
      int ln;
      ea = base + 24'(k);
      ln = big ? 3 - k : k;
      chk(busy === 1'b1, "R9 busy during transfer", 32'(busy), 1);
      chk(done === 1'b0, "R9 no done during transfer", 32'(done), 0);
      chk(mem_addr === ea, "R9 byte address", 32'(mem_addr), 32'(ea));
      chk(mem_we === wr && mem_re === !wr, "R9 access kind", {30'd0, mem_we, mem_re}, {30'd0, wr, !wr});
      if (wr) begin
        chk(mem_wdata === d[8*ln +: 8], "R2 R5 little-endian byte", 32'(mem_wdata), 32'(d[8*ln +: 8]));
        exp_mem[ea[9:0]] = d[8*ln +: 8];
      end
      if (k == 2) req = 1'b0;
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b0 && err === 1'b0, "R9 done after last byte",
        {29'd0, done, busy, err}, 32'h4);
    got_term = term_valid;
    got_term_d = term_data;
  endtask

  task automatic short_op(input logic [2:0] o, input logic [31:0] d, input logic [31:0] a,
                          input bit exp_err, input string tag);
    @(negedge clk);
    req = 1'b1; op = o; data = d; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, {tag, " done next cycle"}, {30'd0, done, busy}, 32'h2);
    chk(err === exp_err, {tag, " error flag"}, 32'(err), 32'(exp_err));
    chk(mem_we === 1'b0 && mem_re === 1'b0, {tag, " no memory access"}, {30'd0, mem_we, mem_re}, 0);
    chk(term_valid === 1'b0, {tag, " no terminal strobe"}, 32'(term_valid), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, prev;
    logic [23:0] b;
    for (int i = 0; i < 1024; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(sp === 24'd0, "R1 sp after reset", 32'(sp), 0);
    chk({busy, done, err, term_valid, mem_we, mem_re} === 6'd0, "R1 idle outputs after reset",
        32'({busy, done, err, term_valid, mem_we, mem_re}), 0);

    // R7 valid set-SP
    short_op(3'd4, 32'h0000_0100, '0, 1'b0, "R7 setsp");
    sp_m = 24'h000100;
    chk(sp === sp_m, "R7 sp loaded", 32'(sp), 32'(sp_m));

    // R2 push sweep
    for (int i = 0; i < 6; i++) begin
      v = 32'hA1B2C3D4 ^ (32'(i) * 32'h1357_9BDF);
      xfer(3'd0, v, 32'hFFFF_FFFF, sp_m, 1'b1, 1'b0, 1'b0);
      sp_m = sp_m + 24'd4;
      chk(sp === sp_m, "R2 sp after push", 32'(sp), 32'(sp_m));
      chk(got_term === 1'b0, "R6 no strobe on push", 32'(got_term), 0);
    end

    // R3 pop sweep
    for (int i = 5; i >= 0; i--) begin
      sp_m = sp_m - 24'd4;
      xfer(3'd1, '0, '0, sp_m, 1'b0, 1'b0, 1'b0);
      v = 32'hA1B2C3D4 ^ (32'(i) * 32'h1357_9BDF);
      chk(rdata === v && rd_le(sp_m) === v, "R3 pop value", rdata, v);
      chk(sp === sp_m, "R3 sp after pop", 32'(sp), 32'(sp_m));
    end

    // R5 stores, junk in upper address byte, unaligned bases
    for (int i = 0; i < 8; i++) begin
      b = 24'h000200 + 24'(i * 5);
      v = 32'h0F1E2D3C + 32'(i) * 32'h0101_0101;
      xfer(3'd3, v, {8'(i * 37 + 1), b}, b, 1'b1, 1'b0, 1'b0);
      chk(got_term === 1'b0, "R6 no strobe on other address", 32'(got_term), 0);
    end
    // R4 loads back
    for (int i = 0; i < 8; i++) begin
      b = 24'h000200 + 24'(i * 5);
      xfer(3'd2, '0, {8'h00, b}, b, 1'b0, 1'b0, 1'b0);
      chk(rdata === rd_le(b), "R4 load little-endian", rdata, rd_le(b));
    end
    // R4 rejected load
    prev = rdata;
    short_op(3'd2, '0, 32'h0100_0200, 1'b1, "R4 bad load");
    chk(rdata === prev, "R4 rdata unchanged after bad load", rdata, prev);

    // R8 fetch big-endian
    for (int i = 0; i < 3; i++) begin
      b = 24'h000200 + 24'(i * 3);
      xfer(3'd5, '0, {8'h00, b}, b, 1'b0, 1'b1, 1'b0);
      chk(rdata === rd_be(b), "R8 fetch big-endian", rdata, rd_be(b));
    end

    // R6 terminal address
    xfer(3'd3, 32'hCAFE_0042, 32'h00FF_FFFC, 24'hFFFFFC, 1'b1, 1'b0, 1'b0);
    chk(got_term === 1'b1, "R6 strobe on terminal store", 32'(got_term), 1);
    chk(got_term_d === 32'hCAFE_0042, "R6 terminal word", got_term_d, 32'hCAFE_0042);
    @(negedge clk);
    chk(term_valid === 1'b0, "R6 strobe one cycle", 32'(term_valid), 0);
    xfer(3'd3, 32'h1234_5678, 32'h00FF_FFF8, 24'hFFFFF8, 1'b1, 1'b0, 1'b0);
    chk(got_term === 1'b0, "R6 no strobe below terminal", 32'(got_term), 0);

    // R7 rejected set-SP
    short_op(3'd4, 32'h0100_0010, '0, 1'b1, "R7 bad setsp");
    chk(sp === sp_m, "R7 sp unchanged", 32'(sp), 32'(sp_m));

    // R12 reserved codes
    short_op(3'd6, 32'h0000_0040, 32'h0000_0200, 1'b1, "R12 op6");
    short_op(3'd7, 32'h0000_0040, 32'h0000_0200, 1'b1, "R12 op7");
    chk(sp === sp_m, "R12 sp unchanged", 32'(sp), 32'(sp_m));

    // R11 wrap at top of address space
    short_op(3'd4, 32'h00FF_FFFC, '0, 1'b0, "R11 setsp top");
    xfer(3'd0, 32'h8899_AABB, '0, 24'hFFFFFC, 1'b1, 1'b0, 1'b0);
    chk(sp === 24'd0, "R11 sp wraps to zero", 32'(sp), 0);
    chk(got_term === 1'b0, "R6 push to terminal word no strobe", 32'(got_term), 0);
    xfer(3'd1, '0, '0, 24'hFFFFFC, 1'b0, 1'b0, 1'b0);
    chk(sp === 24'hFFFFFC, "R11 sp wraps back", 32'(sp), 32'hFFFFFC);
    chk(rdata === 32'h8899_AABB, "R11 value across wrap", rdata, 32'h8899_AABB);

    // R10 request held during busy is ignored
    short_op(3'd4, 32'h0000_0300, '0, 1'b0, "R10 setsp");
    xfer(3'd0, 32'h5566_7788, '0, 24'h000300, 1'b1, 1'b0, 1'b1);
    chk(sp === 24'h000304, "R10 sp after push with held request", 32'(sp), 32'h304);
    xfer(3'd2, '0, 32'h0000_0300, 24'h000300, 1'b0, 1'b0, 1'b0);
    chk(rdata === 32'h5566_7788, "R10 pushed word intact", rdata, 32'h5566_7788);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule